// File: doc/BRIEF.md
# Vector Special-Value Result Fixup

This block corrects the special cases that a short approximation sequence (reciprocal, square root and the like) gets wrong. It receives a vector of 16 single-precision results, the vector of original inputs those results came from, a 21-bit correction table and a per-lane write mask. Each lane's original input falls into one of seven classes. The class picks a 3-bit action from the table. The action either keeps the computed result or replaces it with a fixed special constant.

The table comes with every operation, so one block serves any function. A reciprocal, for example, maps +0 to +infinity and +infinity to +0. Lanes whose mask bit is clear pass the incoming result through untouched. The corrected vector is registered and appears one cycle after a valid input, together with an output strobe.

Top module: `fp_special_fixup`

## Requirements
- R1: Vectors hold 16 lanes of 32-bit single-precision values, lane k at bits [32k+31:32k] of every vector port.
- R2: Each lane's original input is classified as 0 = -infinity, 1 = negative nonzero finite, 2 = -0, 3 = +0, 4 = positive nonzero finite, 5 = +infinity, 6 = NaN (exponent all ones, mantissa nonzero, either sign).
- R3: When classifying, an input with zero exponent and nonzero mantissa is treated as a zero of its own sign (class 2 or 3).
- R4: The action for class i is read from table bits [3i+2:3i].
- R5: Action codes give these outputs: 1 = 0x7FC00000, 2 = 0x80000000, 3 = 0x00000000, 4 = 0xFF7FFFFF, 5 = 0x7F7FFFFF, 6 = 0xFF800000, 7 = 0x7F800000.
- R6: Action code 0 passes that lane's incoming result through unchanged.
- R7: A lane whose mask bit is 0 outputs its incoming result unchanged, whatever its class or table entry.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high, and out_vec then holds the corrected vector. out_vec keeps its value through cycles without a valid input.
- R9: During and after reset, out_valid is 0 and out_vec is all zeros until the first valid input.
- R10: Lanes are corrected independently: each lane's output depends only on its own input, result and mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| res_vec | input | 512 | Approximated results, 16 lanes |
| src_vec | input | 512 | Original inputs that are classified, 16 lanes |
| table_imm | input | 21 | Seven 3-bit action entries |
| lane_mask | input | 16 | Per-lane write enable |
| out_valid | output | 1 | Corrected vector valid |
| out_vec | output | 512 | Corrected vector |

## Verification
The hardest case to reach is a vector in which every lane sits in a different class, some lanes are masked off and a single table has to apply a different action to each class at once. Only such a vector shows that one lane's class never steers another lane's table entry. The bench builds such vectors from denormals of both signs, NaNs with either sign bit, infinities and ordinary numbers. It pairs them with tables whose seven entries all differ and with mask patterns that alternate, and it compares every lane against a model written from the requirements. A table walk first covers each class and each action alone, with the mask fully set.

// File: rtl/fp_special_fixup.sv
module fp_special_fixup #(
  parameter int LANES = 16,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] res_vec,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] src_vec,
  input  logic [20:0]                    table_imm,
  input  logic [LANES-1:0]               lane_mask,
  output logic                           out_valid,
  output logic [LANES*(1+EXP_W+MAN_W)-1:0] out_vec
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int VEC_W = LANES * W;
  localparam int ACT_W = 3;

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] MAXF = {1'b0, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
  localparam logic [W-1:0] INF  = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [W-1:0] SGN  = {1'b1, {(W-1){1'b0}}};

  logic [VEC_W-1:0] nxt_vec;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0]     src, res, fixed;
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic [2:0]       cls;
    logic [ACT_W-1:0] act;

    assign src = src_vec[l*W +: W];
    assign res = res_vec[l*W +: W];
    assign sgn = src[W-1];
    assign ex  = src[W-2 -: EXP_W];
    assign man = src[MAN_W-1:0];

    always_comb begin
      if (&ex)       cls = (man != '0) ? 3'd6 : (sgn ? 3'd0 : 3'd5);
      else if (ex == '0) cls = sgn ? 3'd2 : 3'd3;
      else           cls = sgn ? 3'd1 : 3'd4;
    end

    assign act = table_imm[int'(cls)*ACT_W +: ACT_W];

    always_comb begin
      case (act)
        3'd1:    fixed = QNAN;
        3'd2:    fixed = SGN;
        3'd3:    fixed = '0;
        3'd4:    fixed = MAXF | SGN;
        3'd5:    fixed = MAXF;
        3'd6:    fixed = INF | SGN;
        3'd7:    fixed = INF;
        default: fixed = res;
      endcase
    end

    assign nxt_vec[l*W +: W] = lane_mask[l] ? fixed : res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= nxt_vec;
    end
  end
endmodule

// File: rtl/fp_special_fixup_chk.sv
module fp_special_fixup_chk #(
  parameter int LANES = 16,
  parameter int W     = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [LANES*W-1:0] res_vec,
  input logic [20:0]        table_imm,
  input logic [LANES-1:0]   lane_mask,
  input logic               out_valid,
  input logic [LANES*W-1:0] out_vec
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_vec)); // R8
  AST_ALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && table_imm == '0) |=> out_vec == $past(res_vec)); // R6

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_MASKED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_mask[l]) |=> out_vec[l*W +: W] == $past(res_vec[l*W +: W])); // R7
  end
endmodule

bind fp_special_fixup fp_special_fixup_chk #(.LANES(LANES), .W(1+EXP_W+MAN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_vec(res_vec),
  .table_imm(table_imm), .lane_mask(lane_mask), .out_valid(out_valid), .out_vec(out_vec)
);

// File: tb/fp_special_fixup_tb_top.sv
module fp_special_fixup_tb_top;
  localparam int L = 16;
  localparam int W = 32;
  localparam int NROW = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [L*W-1:0]   res_vec = '0;
  logic [L*W-1:0]   src_vec = '0;
  logic [20:0]      table_imm = '0;
  logic [L-1:0]     lane_mask = '0;
  logic             out_valid;
  logic [L*W-1:0]   out_vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_special_fixup dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_vec(res_vec),
    .src_vec(src_vec), .table_imm(table_imm), .lane_mask(lane_mask),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  // row: {src, res, table, expected}, applied to all lanes with full mask
  localparam logic [116:0] ROWS [NROW] = '{
    {32'hFF800000, 32'h3F800000, 21'h000007,  32'h7F800000},
    {32'hBF800000, 32'h3F800000, 21'h000020,  32'hFF7FFFFF},
    {32'h80000000, 32'h3F800000, 21'h0000C0,  32'h00000000},
    {32'h00000001, 32'h3F800000, 21'h000400,  32'h80000000},
    {32'h3F800000, 32'h40000000, 21'h005000,  32'h7F7FFFFF},
    {32'h7F800000, 32'h3F800000, 21'h030000,  32'hFF800000},
    {32'h7FC00001, 32'h3F800000, 21'h040000,  32'h7FC00000},
    {32'h807FFFFF, 32'h12345678, 21'h1FFE3F,  32'h12345678},
    {32'hFF800001, 32'h3F800000, 21'h0FFFFF,  32'h00000000}
  };

  function automatic logic [31:0] model(logic [31:0] s, logic [31:0] r, logic [20:0] t, logic m);
    int c;
    logic [2:0] a;
    if (!m) return r;
    if (s[30:23] == 8'hFF) c = (s[22:0] != 0) ? 6 : (s[31] ? 0 : 5);
    else if (s[30:23] == 8'h00) c = s[31] ? 2 : 3;
    else c = s[31] ? 1 : 4;
    a = t[3*c +: 3];
    case (a)
      3'd0: return r;
      3'd1: return 32'h7FC00000;
      3'd2: return 32'h80000000;
      3'd3: return 32'h00000000;
      3'd4: return 32'hFF7FFFFF;
      3'd5: return 32'h7F7FFFFF;
      3'd6: return 32'hFF800000;
      default: return 32'h7F800000;
    endcase
  endfunction

  task automatic check(string req, logic [L*W-1:0] act, logic [L*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [L*W-1:0] s, logic [L*W-1:0] r, logic [20:0] t, logic [L-1:0] m);
    @(negedge clk);
    src_vec = s; res_vec = r; table_imm = t; lane_mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [L*W-1:0] model_vec(logic [L*W-1:0] s, logic [L*W-1:0] r,
                                               logic [20:0] t, logic [L-1:0] m);
    logic [L*W-1:0] v;
    for (int k = 0; k < L; k++) v[k*W +: W] = model(s[k*W +: W], r[k*W +: W], t, m[k]);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [L*W-1:0] s, r, e, held;
    logic [31:0] mix [8];
    repeat (3) @(negedge clk);
    check("R9 reset valid", {511'd0, out_valid}, '0);
    check("R9 reset data", out_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {511'd0, out_valid}, '0);

    // R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < NROW; i++) begin
      apply({L{ROWS[i][116:85]}}, {L{ROWS[i][84:53]}}, ROWS[i][52:32], '1);
      check($sformatf("R2/R5 row %0d valid", i), {511'd0, out_valid}, {511'd0, 1'b1});
      check($sformatf("R2/R3/R4/R5 row %0d data", i), out_vec, {L{ROWS[i][31:0]}});
    end

    // R10: every lane a different class, distinct actions per class
    mix = '{32'hFF800000, 32'hC1200000, 32'h80000010, 32'h00400000,
            32'h3F000000, 32'h7F800000, 32'hFFC00000, 32'h7F800001};
    for (int k = 0; k < L; k++) begin
      s[k*W +: W] = mix[k % 8];
      r[k*W +: W] = 32'h40000000 + k;
    end
    apply(s, r, {3'd1, 3'd7, 3'd4, 3'd3, 3'd2, 3'd0, 3'd6}, '1);
    e = model_vec(s, r, {3'd1, 3'd7, 3'd4, 3'd3, 3'd2, 3'd0, 3'd6}, '1);
    check("R10 mixed lanes", out_vec, e);

    // R7: masked lanes keep result
    apply(s, r, 21'h1FFFFF, 16'hA5A5);
    e = model_vec(s, r, 21'h1FFFFF, 16'hA5A5);
    check("R7 mask A5A5", out_vec, e);
    apply(s, r, {3'd5, 3'd5, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6}, 16'h0000);
    check("R7 mask all clear", out_vec, r);

    // R6: all-keep table
    apply(s, r, 21'h0, '1);
    check("R6 all keep", out_vec, r);

    // R1: lane position, one lane different
    s = {L{32'h3F800000}}; r = {L{32'h11111111}};
    s[5*W +: W] = 32'h80000000;
    apply(s, r, 21'h0000C0, '1);
    e = r; e[5*W +: W] = 32'h00000000;
    check("R1 lane 5 position", out_vec, e);

    // R8: hold while idle
    held = out_vec;
    @(negedge clk);
    src_vec = '1; res_vec = '0; table_imm = 21'h1FFFFF; lane_mask = '1;
    repeat (2) @(negedge clk);
    check("R8 idle valid low", {511'd0, out_valid}, '0);
    check("R8 idle hold", out_vec, held);

    // R8: back-to-back inputs
    @(negedge clk);
    src_vec = {L{32'h7F800000}}; res_vec = {L{32'h1}}; table_imm = 21'h030000; in_valid = 1'b1;
    @(negedge clk);
    check("R8 b2b first", out_vec, {L{32'hFF800000}});
    src_vec = {L{32'hFF800000}}; table_imm = 21'h000001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 b2b second", out_vec, {L{32'h7FC00000}});
    check("R8 b2b valid", {511'd0, out_valid}, {511'd0, 1'b1});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule